// File: doc/BRIEF.md
# Serial Real-Time Clock with Backup SRAM

This block is a serially attached slave that keeps wall-clock time as a free-running count of seconds. It also holds a small backup SRAM window, a few timestamp-style registers, a pair of control words and four fixed test words. A host reaches it through a bit-serial link that is qualified by a select line. The host raises `sel` and presents one bit on `bit_in` in each cycle where `bit_vld` is high. The first 32 bits form a command and the next 32 bits form a data word. Both words travel most significant bit first.

In the command word, bit 31 chooses the direction and bits 30..8 carry the register address. The top address bit of the 24-bit address shares bit 31 with the direction flag, so it always decodes as zero. Bits 7..0 are ignored. For a read, the selected register is copied when the last command bit arrives and then shifts out on `bit_out`. For a write, the register takes the data word when its final bit arrives. The seconds counter advances on each pulse of an external 1 Hz strobe. Two power-status inputs are sampled into a read-only control word.

Top module: `rtc_serial_slave`

## Requirements
- R1: While `sel` is high, each cycle with `bit_vld` high shifts in one bit, MSB first. Bit 31 of the 32-bit command word set means write and clear means read. The address is `{1'b0, cmd[30:8]}`, and `cmd[7:0]` has no effect.
- R2: A read puts the addressed 32-bit value on `bit_out`, MSB first. Its bit 31 is on `bit_out` from the clock edge that takes the last command bit, and each later bit appears at the edge that takes the next data-phase strobe.
- R3: A write updates the addressed register at the clock edge that takes the 32nd data bit. A later read of that register returns the written value.
- R4: The seconds counter at 0x200000 rises by one at each clock edge where `tick_1hz` is high, and it wraps from 0xFFFFFFFF to 0.
- R5: When a bus write to 0x200000 completes in the same cycle as a tick, the written value is kept and the increment is dropped.
- R6: Sixteen SRAM words at 0x200001..0x200010 can be read and written. The offset word at 0x200004 is an ordinary word of this window.
- R7: The snapshot register (0x204000), the wake-up timer (0x210000), the sleep timer (0x210001) and control word 1 (0x21000d) can be read and written.
- R8: The test words at 0x210004..0x210007 are read-only. Word k (k = 0..3) reads `TEST_SEED | k`, which is 0x5EC00000 | k by default, and writes to them have no effect.
- R9: Control word 0 at 0x21000c is read-only. Bit 11 is the sampled `pwr_unstable` input, bit 9 is the sampled `batt_low` input, and every other bit is 0. The inputs are sampled every clock cycle.
- R10: Reads of unmapped addresses return 0. Writes to unmapped or read-only addresses change no register.
- R11: A low `sel` abandons any partial command or data word. No write is done, `bit_out` goes to 0, and the next strobed bit starts a new command word.
- R12: After reset the counter and every writable register read 0, and `bit_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| pwr_unstable | input | 1 | Power was unstable (status input) |
| batt_low | input | 1 | Backup battery is low (status input) |
| sel | input | 1 | Transaction select, active high |
| bit_vld | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Serial data into the block |
| bit_out | output | 1 | Serial read data out of the block |

## Verification
The first bit of a read word is due on `bit_out` one edge after the last command bit. Each further bit is due one edge after the strobe that consumes the bit before it. The bench therefore samples `bit_out` at the falling edge before it raises each data strobe. A write lands on the edge of its final data bit, and a tick lands on the edge where it is high. Counter and register checks are made by reads started after those edges, and the priority case drives a tick together with the last data bit. Control word 0 lags its inputs by one edge, so the bench changes the inputs several cycles before it reads that word.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 24;
   localparam int POS_W  = $clog2(WORD_W);

   localparam logic [ADDR_W-1:0] A_COUNT  = 24'h200000;
   localparam logic [ADDR_W-1:0] A_SRAM0  = 24'h200001;
   localparam logic [ADDR_W-1:0] A_SNAP   = 24'h204000;
   localparam logic [ADDR_W-1:0] A_WAKE   = 24'h210000;
   localparam logic [ADDR_W-1:0] A_SLEEP  = 24'h210001;
   localparam logic [ADDR_W-1:0] A_TEST0  = 24'h210004;
   localparam logic [ADDR_W-1:0] A_CTRL0  = 24'h21000c;
   localparam logic [ADDR_W-1:0] A_CTRL1  = 24'h21000d;

   typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/rtc_ser_frame.sv
module rtc_ser_frame
   import rtc_ser_pkg::*;
#(
   parameter int WW = WORD_W,
   parameter int AW = ADDR_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          bit_vld,
   input  logic          bit_in,
   input  logic [WW-1:0] rd_word,
   output logic [AW-1:0] acc_addr,
   output logic          wr_en,
   output logic [WW-1:0] wr_data,
   output logic          bit_out,
   output logic          in_data,
   output logic [$clog2(WW)-1:0] frame_pos
);
   localparam int PW = $clog2(WW);

   if (WW != AW + 8) begin : g_bad_pack
      $error("command word must be the address width plus eight");
   end
   if ((1 << PW) != WW) begin : g_bad_word
      $error("word width must be a power of two");
   end

   phase_e        phase_q;
   logic [PW-1:0] pos_q;
   logic [WW-2:0] sh_q;
   logic [WW-1:0] tx_q;
   logic [AW-1:0] addr_q;
   logic          wr_q;
   logic          step;
   logic          last;
   logic          cmd_flag;
   logic [AW-2:0] cmd_addr;

   assign step     = sel && bit_vld;
   assign last     = (pos_q == PW'(WW - 1));
   assign cmd_flag = sh_q[WW-2];
   assign cmd_addr = sh_q[WW-3 -: (AW-1)];
   assign acc_addr = (phase_q == PH_CMD) ? {1'b0, cmd_addr} : addr_q;
   assign wr_data  = {sh_q, bit_in};
   assign wr_en    = step && last && (phase_q == PH_DATA) && wr_q;
   assign bit_out  = tx_q[WW-1];
   assign in_data  = (phase_q == PH_DATA);
   assign frame_pos = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;
         pos_q   <= '0;
         sh_q    <= '0;
         tx_q    <= '0;
         addr_q  <= '0;
         wr_q    <= 1'b0;
      end else if (!sel) begin
         phase_q <= PH_CMD;
         pos_q   <= '0;
         sh_q    <= '0;
         tx_q    <= '0;
      end else if (bit_vld) begin
         sh_q  <= {sh_q[WW-3:0], bit_in};
         pos_q <= pos_q + 1'b1;
         if (phase_q == PH_CMD) begin
            if (last) begin
               phase_q <= PH_DATA;
               addr_q  <= {1'b0, cmd_addr};
               wr_q    <= cmd_flag;
               tx_q    <= cmd_flag ? '0 : rd_word;
            end
         end else begin
            tx_q <= {tx_q[WW-2:0], 1'b0};
            if (last) phase_q <= PH_CMD;
         end
      end
   end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] count
);
   if (W < 1) begin : g_bad_w
      $error("counter width must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (ld)   count <= ld_val;
      else if (tick) count <= count + 1'b1;
   end
endmodule

// File: rtl/rtc_regmap.sv
module rtc_regmap
   import rtc_ser_pkg::*;
#(
   parameter int                WW          = WORD_W,
   parameter int                AW          = ADDR_W,
   parameter int                SRAM_WORDS  = 16,
   parameter int                TEST_WORDS  = 4,
   parameter int                UNSTAB_BIT  = 11,
   parameter int                LOWBAT_BIT  = 9,
   parameter logic [WW-1:0]     TEST_SEED   = 32'h5EC00000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [WW-1:0] wr_data,
   input  logic [WW-1:0] count,
   input  logic          pwr_unstable,
   input  logic          batt_low,
   output logic          cnt_ld,
   output logic [WW-1:0] rd_word
);
   if (SRAM_WORDS < 1 || SRAM_WORDS > 256) begin : g_bad_sram
      $error("SRAM window size out of range");
   end
   if (UNSTAB_BIT >= WW || LOWBAT_BIT >= WW || UNSTAB_BIT == LOWBAT_BIT) begin : g_bad_flags
      $error("status bit positions invalid");
   end
   if (TEST_WORDS < 1 || TEST_WORDS > 16) begin : g_bad_test
      $error("test word count out of range");
   end

   logic [WW-1:0] sram_q [SRAM_WORDS];
   logic [SRAM_WORDS-1:0] sram_hit;
   logic [TEST_WORDS-1:0] test_hit;
   logic [WW-1:0] test_val [TEST_WORDS];
   logic [WW-1:0] snap_q, wake_q, sleep_q, ctrl1_q, ctrl0_w;
   logic          unst_q, low_q;

   assign cnt_ld = wr_en && (addr == A_COUNT);

   for (genvar i = 0; i < SRAM_WORDS; i++) begin : g_sram
      localparam logic [AW-1:0] MY_A = AW'(int'(A_SRAM0) + i);
      assign sram_hit[i] = (addr == MY_A);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   sram_q[i] <= '0;
         else if (wr_en && sram_hit[i]) sram_q[i] <= wr_data;
      end
   end

   for (genvar k = 0; k < TEST_WORDS; k++) begin : g_test
      localparam logic [AW-1:0] MY_A = AW'(int'(A_TEST0) + k);
      assign test_hit[k] = (addr == MY_A);
      assign test_val[k] = TEST_SEED | WW'(k);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q  <= '0;
         wake_q  <= '0;
         sleep_q <= '0;
         ctrl1_q <= '0;
         unst_q  <= 1'b0;
         low_q   <= 1'b0;
      end else begin
         unst_q <= pwr_unstable;
         low_q  <= batt_low;
         if (wr_en) begin
            if (addr == A_SNAP)  snap_q  <= wr_data;
            if (addr == A_WAKE)  wake_q  <= wr_data;
            if (addr == A_SLEEP) sleep_q <= wr_data;
            if (addr == A_CTRL1) ctrl1_q <= wr_data;
         end
      end
   end

   always_comb begin
      ctrl0_w = '0;
      ctrl0_w[UNSTAB_BIT] = unst_q;
      ctrl0_w[LOWBAT_BIT] = low_q;
   end

   always_comb begin
      rd_word = '0;
      if (addr == A_COUNT) rd_word = count;
      if (addr == A_SNAP)  rd_word = snap_q;
      if (addr == A_WAKE)  rd_word = wake_q;
      if (addr == A_SLEEP) rd_word = sleep_q;
      if (addr == A_CTRL0) rd_word = ctrl0_w;
      if (addr == A_CTRL1) rd_word = ctrl1_q;
      for (int i = 0; i < SRAM_WORDS; i++)
         if (sram_hit[i]) rd_word = sram_q[i];
      for (int k = 0; k < TEST_WORDS; k++)
         if (test_hit[k]) rd_word = test_val[k];
   end
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
   import rtc_ser_pkg::*;
#(
   parameter int            SRAM_WORDS = 16,
   parameter int            TEST_WORDS = 4,
   parameter int            UNSTAB_BIT = 11,
   parameter int            LOWBAT_BIT = 9,
   parameter logic [31:0]   TEST_SEED  = 32'h5EC00000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1hz,
   input  logic pwr_unstable,
   input  logic batt_low,
   input  logic sel,
   input  logic bit_vld,
   input  logic bit_in,
   output logic bit_out
);
   logic [ADDR_W-1:0] acc_addr;
   logic [WORD_W-1:0] rd_word, wr_data, cnt_q;
   logic              wr_en, cnt_ld, in_data;
   logic [POS_W-1:0]  frame_pos;

   rtc_ser_frame #(.WW(WORD_W), .AW(ADDR_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sel(sel), .bit_vld(bit_vld), .bit_in(bit_in),
      .rd_word(rd_word), .acc_addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
      .bit_out(bit_out), .in_data(in_data), .frame_pos(frame_pos)
   );

   rtc_regmap #(
      .WW(WORD_W), .AW(ADDR_W), .SRAM_WORDS(SRAM_WORDS), .TEST_WORDS(TEST_WORDS),
      .UNSTAB_BIT(UNSTAB_BIT), .LOWBAT_BIT(LOWBAT_BIT), .TEST_SEED(TEST_SEED)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
      .count(cnt_q), .pwr_unstable(pwr_unstable), .batt_low(batt_low),
      .cnt_ld(cnt_ld), .rd_word(rd_word)
   );

   rtc_sec_counter #(.W(WORD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .ld(cnt_ld),
      .ld_val(wr_data), .count(cnt_q)
   );
endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk
   import rtc_ser_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              tick,
   input logic              cnt_ld,
   input logic [WORD_W-1:0] wr_data,
   input logic [WORD_W-1:0] cnt_q,
   input logic              in_data,
   input logic [POS_W-1:0]  frame_pos,
   input logic              bit_out
);
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_ld) |=> (cnt_q == $past(cnt_q) + 32'd1));           // R4
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_ld) |=> $stable(cnt_q));                            // R4
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld |=> (cnt_q == $past(wr_data)));                             // R5
   AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (!in_data && frame_pos == '0 && !bit_out));               // R11
endmodule

bind rtc_serial_slave rtc_serial_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .tick(tick_1hz), .cnt_ld(cnt_ld),
   .wr_data(wr_data), .cnt_q(cnt_q), .in_data(in_data),
   .frame_pos(frame_pos), .bit_out(bit_out)
);

// File: tb/rtc_serial_slave_bench.sv
module rtc_serial_slave_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic tick_1hz = 1'b0, pwr_unstable = 1'b0, batt_low = 1'b0;
   logic sel = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
   logic bit_out;
   int   checks = 0, errors = 0;
   bit   done = 1'b0;

   localparam logic [31:0] SEED = 32'h5EC00000;

   typedef struct { string tag; logic [31:0] val; } exp_t;
   exp_t        exp_q[$];
   logic [31:0] act_q[$];

   always #5 clk = ~clk;

   rtc_serial_slave u_rtc_serial_slave (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_unstable(pwr_unstable),
      .batt_low(batt_low), .sel(sel), .bit_vld(bit_vld), .bit_in(bit_in),
      .bit_out(bit_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive_bit(input logic b, input logic tk);
      @(negedge clk);
      sel = 1'b1; bit_vld = 1'b1; bit_in = b; tick_1hz = tk;
   endtask

   task automatic end_xfer();
      @(negedge clk);
      bit_vld = 1'b0; bit_in = 1'b0; tick_1hz = 1'b0; sel = 1'b0;
   endtask

   task automatic send_bits(input logic [31:0] w, input int n);
      for (int i = 31; i >= 32 - n; i--) drive_bit(w[i], 1'b0);
   endtask

   task automatic reg_write(input logic [23:0] a, input logic [31:0] d, input logic tk_last);
      send_bits({1'b1, a[22:0], 8'h00}, 32);
      for (int i = 31; i >= 0; i--) drive_bit(d[i], tk_last && (i == 0));
      end_xfer();
   endtask

   task automatic reg_read(input logic [23:0] a, input logic [7:0] low,
                           input logic [31:0] exp, input string tag);
      exp_t e;
      logic [31:0] got;
      e.tag = tag; e.val = exp;
      exp_q.push_back(e);
      send_bits({1'b0, a[22:0], low}, 32);
      for (int i = 31; i >= 0; i--) begin
         @(negedge clk);
         got[i] = bit_out;
         bit_vld = 1'b1; bit_in = 1'b0;
      end
      act_q.push_back(got);
      end_xfer();
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   // scoreboard monitor: pairs each finished read word with its expected item
   always @(negedge clk) begin
      exp_t        e;
      logic [31:0] a;
      if (act_q.size() > 0 && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         a = act_q.pop_front();
         check(e.tag, a, e.val);
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R12 bit_out in reset", {31'd0, bit_out}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      reg_read(24'h200000, 8'h00, 32'd0, "R12 counter after reset");
      reg_read(24'h200001, 8'h00, 32'd0, "R12 sram after reset");
      reg_read(24'h21000d, 8'h00, 32'd0, "R12 ctrl1 after reset");

      repeat (3) pulse_tick();
      reg_read(24'h200000, 8'h00, 32'd3, "R4 three ticks");
      reg_read(24'h200000, 8'hFF, 32'd3, "R1 low command byte ignored");

      reg_write(24'h200000, 32'hFFFF_FFFE, 1'b0);
      pulse_tick(); pulse_tick();
      reg_read(24'h200000, 8'h00, 32'd0, "R4 wrap to zero");

      reg_write(24'h200000, 32'h0000_1000, 1'b1);
      reg_read(24'h200000, 8'h00, 32'h0000_1000, "R5 write beats tick");
      pulse_tick();
      reg_read(24'h200000, 8'h00, 32'h0000_1001, "R4 tick after load");

      reg_write(24'h200004, 32'hB1A5_0001, 1'b0);
      reg_write(24'h200010, 32'hA5A5_5A5A, 1'b0);
      reg_write(24'h200001, 32'h0000_1111, 1'b0);
      reg_read(24'h200004, 8'h00, 32'hB1A5_0001, "R6 offset word");
      reg_read(24'h200010, 8'h00, 32'hA5A5_5A5A, "R6 last sram word");
      reg_read(24'h200001, 8'h00, 32'h0000_1111, "R6 first sram word");

      reg_write(24'h204000, 32'h0BAD_F00D, 1'b0);
      reg_write(24'h210000, 32'h1234_5678, 1'b0);
      reg_write(24'h210001, 32'h8765_4321, 1'b0);
      reg_write(24'h21000d, 32'h0000_00C3, 1'b0);
      reg_read(24'h204000, 8'h00, 32'h0BAD_F00D, "R7 snapshot");
      reg_read(24'h210000, 8'h00, 32'h1234_5678, "R3 wake timer");
      reg_read(24'h210001, 8'h00, 32'h8765_4321, "R7 sleep timer");
      reg_read(24'h21000d, 8'h00, 32'h0000_00C3, "R7 ctrl1");

      reg_read(24'h210004, 8'h00, SEED | 32'd0, "R8 test word 0");
      reg_read(24'h210007, 8'h00, SEED | 32'd3, "R8 test word 3");
      reg_write(24'h210005, 32'h1234_5678, 1'b0);
      reg_read(24'h210005, 8'h00, SEED | 32'd1, "R8 test word write ignored");

      pwr_unstable = 1'b1; batt_low = 1'b0;
      repeat (3) @(negedge clk);
      reg_read(24'h21000c, 8'h00, 32'h0000_0800, "R9 unstable flag");
      batt_low = 1'b1;
      repeat (3) @(negedge clk);
      reg_read(24'h21000c, 8'h00, 32'h0000_0A00, "R9 both flags");
      reg_write(24'h21000c, 32'hFFFF_FFFF, 1'b0);
      reg_read(24'h21000c, 8'h00, 32'h0000_0A00, "R9 ctrl0 write ignored");
      pwr_unstable = 1'b0;
      repeat (3) @(negedge clk);
      reg_read(24'h21000c, 8'h00, 32'h0000_0200, "R9 low battery only");

      reg_read(24'h200011, 8'h00, 32'd0, "R10 unmapped read past sram");
      reg_read(24'h210008, 8'h00, 32'd0, "R10 unmapped read past tests");
      reg_write(24'h200011, 32'h0000_DEAD, 1'b0);
      reg_write(24'h204001, 32'h0000_BEEF, 1'b0);
      reg_read(24'h200010, 8'h00, 32'hA5A5_5A5A, "R10 neighbour sram intact");
      reg_read(24'h204000, 8'h00, 32'h0BAD_F00D, "R10 snapshot intact");

      send_bits({1'b1, 23'h21000d, 8'h00}, 16);
      end_xfer();
      reg_read(24'h21000d, 8'h00, 32'h0000_00C3, "R11 abort in command");
      send_bits({1'b1, 23'h21000d, 8'h00}, 32);
      send_bits(32'hFFFF_FFFF, 20);
      end_xfer();
      check("R11 bit_out after abort", {31'd0, bit_out}, 32'd0);
      reg_read(24'h21000d, 8'h00, 32'h0000_00C3, "R11 abort in data");
      reg_read(24'h200000, 8'h00, 32'h0000_1001, "R2 counter read after aborts");

      repeat (5) @(negedge clk);
      if (exp_q.size() != 0) check("R2 pending reads", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL all requirements: watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule